// File: doc/BRIEF.md
# Four-Mode Significand Rounding Stage

This block takes the already normalized, unrounded result of a floating-point add or multiply and packs it into a single-precision word. The inputs are a sign, a biased exponent, a significand that includes the leading one, and three extra low-order bits: guard, round and sticky. A two-bit select chooses one of four rounding policies. Each policy decides whether the significand is truncated or incremented by one unit in the last place.

An increment can carry out of the top of the significand, which happens when every significand bit is one. In that case the stage shifts the significand back to 1.000…0 and adds one to the exponent. If that pushes the exponent to its all-ones code, the stage returns an infinity with the input's sign and raises an overflow flag. A separate flag reports that precision was lost, which is true whenever any of the three extra bits is set.

A parameter sets whether the result is held in an output register or leaves the stage combinationally. The default registers it, so the result appears one clock after its inputs. Exponent and significand widths are also parameters, checked at elaboration. The defaults give the 32-bit single format.

Top module: `rnd_unit`

## Requirements
- R1: With mode code 2'b00 (nearest, ties to even), the significand is incremented when the extra bits {guard,round,sticky} exceed 3'b100, and truncated when they are below it.
- R2: With mode code 2'b00 and extra bits exactly 3'b100, the significand is incremented only when its least significant bit is 1, so the rounded result always has an even last bit.
- R3: With mode code 2'b01 (toward zero), the significand is always truncated, for either sign and any extra bits.
- R4: With mode code 2'b10 (toward plus infinity), the significand is incremented exactly when the sign is 0 and at least one extra bit is 1.
- R5: With mode code 2'b11 (toward minus infinity), the significand is incremented exactly when the sign is 1 and at least one extra bit is 1.
- R6: An increment of an all-ones significand yields fraction zero and an exponent one larger than the input exponent.
- R7: The inexact output is 1 exactly when at least one of guard, round and sticky is 1.
- R8: When the exponent after rounding equals the all-ones code (255), the word is {sign, 8'hFF, 23'h0} and the overflow output is 1. Otherwise the overflow output is 0.
- R9: Bit 31 of the result word always equals the input sign.
- R10: When guard, round and sticky are all 0, the word is {sign, exponent, significand[22:0]} unchanged, whatever the mode.
- R11: In the registered configuration, the result for inputs present at a rising clock edge appears after that edge. While reset is low, the word and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | EXP_W (8) | Biased exponent |
| in_sig | input | SIG_W (24) | Significand including the leading one at the top bit |
| in_guard | input | 1 | First bit below the last significand bit |
| in_round | input | 1 | Second bit below the last significand bit |
| in_sticky | input | 1 | OR of all bits further below |
| in_mode | input | 2 | Rounding policy: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_word | output | EXP_W+SIG_W (32) | Packed sign, exponent and fraction |
| out_inexact | output | 1 | Precision was lost |
| out_overflow | output | 1 | Result became infinity |

## Verification
The hardest case to reach is a carry out of the significand that lands exactly on the top exponent: it needs an all-ones significand, exponent 254, and a mode/sign/extra-bit mix that asks for an increment. The bench sweeps every mode, both signs and all eight extra-bit patterns. It does this over a set of significands that includes all-ones, all-ones minus one, and odd and even values, crossed with exponents 1, 127, 253 and 254. That sweep reaches the carry-into-overflow corner under every rounding policy that increments, and the tie case with both parities of the last bit.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } rnd_mode_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
   import rnd_pkg::*;
(
   input  logic       mode_i_bit1,
   input  logic       mode_i_bit0,
   input  logic       sign_i,
   input  logic       lsb_i,
   input  logic       guard_i,
   input  logic       round_i,
   input  logic       sticky_i,
   output logic       bump_o,
   output logic       lost_o
);

   rnd_mode_e mode;
   logic      below_any;

   always_comb begin
      mode      = rnd_mode_e'({mode_i_bit1, mode_i_bit0});
      below_any = guard_i | round_i | sticky_i;
      lost_o    = below_any;
      unique case (mode)
         RM_NEAR_EVEN: bump_o = guard_i & (round_i | sticky_i | lsb_i);
         RM_TO_ZERO:   bump_o = 1'b0;
         RM_TO_POS:    bump_o = below_any & ~sign_i;
         RM_TO_NEG:    bump_o = below_any & sign_i;
         default:      bump_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rnd_apply.sv
module rnd_apply #(
   parameter int EXP_W = 8,
   parameter int SIG_W = 24
) (
   input  logic                   sign_i,
   input  logic [EXP_W-1:0]       exp_i,
   input  logic [SIG_W-1:0]       sig_i,
   input  logic                   bump_i,
   output logic [EXP_W+SIG_W-1:0] word_o,
   output logic                   ovf_o
);

   localparam int FRAC_W = SIG_W - 1;
   localparam logic [EXP_W:0] EXP_TOP = {1'b0, {EXP_W{1'b1}}};

   logic [SIG_W:0]    sum;
   logic              carry;
   logic [FRAC_W-1:0] frac;
   logic [EXP_W:0]    exp_next;

   always_comb begin
      sum      = {1'b0, sig_i} + {{SIG_W{1'b0}}, bump_i};
      carry    = sum[SIG_W];
      frac     = carry ? sum[SIG_W-1:1] : sum[FRAC_W-1:0];
      exp_next = {1'b0, exp_i} + {{EXP_W{1'b0}}, carry};
      ovf_o    = (exp_next >= EXP_TOP);
      if (ovf_o) begin
         word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
         word_o = {sign_i, exp_next[EXP_W-1:0], frac};
      end
   end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
   import rnd_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int SIG_W   = 24,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_sign,
   input  logic [EXP_W-1:0]       in_exp,
   input  logic [SIG_W-1:0]       in_sig,
   input  logic                   in_guard,
   input  logic                   in_round,
   input  logic                   in_sticky,
   input  logic [1:0]             in_mode,
   output logic [EXP_W+SIG_W-1:0] out_word,
   output logic                   out_inexact,
   output logic                   out_overflow
);

   localparam int WORD_W = EXP_W + SIG_W;
   localparam int FRAC_W = SIG_W - 1;
   localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

   if (EXP_W < 2) begin : g_bad_exp
      $error("rnd_unit: EXP_W must be at least 2");
   end
   if (SIG_W < 2) begin : g_bad_sig
      $error("rnd_unit: SIG_W must be at least 2");
   end

   logic              bump;
   logic              lost;
   logic [WORD_W-1:0] word_c;
   logic              ovf_c;

   rnd_decide u_decide (
      .mode_i_bit1 (in_mode[1]),
      .mode_i_bit0 (in_mode[0]),
      .sign_i      (in_sign),
      .lsb_i       (in_sig[0]),
      .guard_i     (in_guard),
      .round_i     (in_round),
      .sticky_i    (in_sticky),
      .bump_o      (bump),
      .lost_o      (lost)
   );

   rnd_apply #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_apply (
      .sign_i (in_sign),
      .exp_i  (in_exp),
      .sig_i  (in_sig),
      .bump_i (bump),
      .word_o (word_c),
      .ovf_o  (ovf_c)
   );

   if (OUT_REG) begin : g_reg
      logic armed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_word     <= '0;
            out_inexact  <= 1'b0;
            out_overflow <= 1'b0;
            armed        <= 1'b0;
         end else begin
            out_word     <= word_c;
            out_inexact  <= lost;
            out_overflow <= ovf_c;
            armed        <= 1'b1;
         end
      end

      // R8: an overflow always carries the infinity encoding
      a_r8_overflow_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
         out_overflow |-> (out_word[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}}));

      // R9: sign of the word follows the sign presented one edge earlier
      a_r9_sign_kept: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         out_word[WORD_W-1] == $past(in_sign));

      // R7: the loss flag tracks the extra bits of the previous edge
      a_r7_inexact_tracks: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         out_inexact == $past(in_guard | in_round | in_sticky));

      // R3: toward zero leaves fraction and exponent untouched
      a_r3_zero_truncates: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(in_mode) == RM_TO_ZERO && $past(in_exp) != EXP_ONES)
         |-> (out_word[WORD_W-2:0] == $past({in_exp, in_sig[FRAC_W-1:0]}) && !out_overflow));

      // R10: exact inputs pass straight through in every mode
      a_r10_exact_passes: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         ($past(!(in_guard | in_round | in_sticky)) && $past(in_exp) != EXP_ONES)
         |-> (out_word[WORD_W-2:0] == $past({in_exp, in_sig[FRAC_W-1:0]}) && !out_inexact));
   end else begin : g_comb
      always_comb begin
         out_word     = word_c;
         out_inexact  = lost;
         out_overflow = ovf_c;
      end

      // R8: an overflow always carries the infinity encoding
      a_r8_overflow_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
         out_overflow |-> (out_word[WORD_W-2:0] == {EXP_ONES, {FRAC_W{1'b0}}}));

      // R9: sign is carried straight through
      a_r9_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
         out_word[WORD_W-1] == in_sign);

      // R7: loss flag follows the extra bits
      a_r7_inexact_tracks: assert property (@(posedge clk) disable iff (!rst_n)
         out_inexact == (in_guard | in_round | in_sticky));

      // R3: toward zero leaves fraction and exponent untouched
      a_r3_zero_truncates: assert property (@(posedge clk) disable iff (!rst_n)
         (in_mode == RM_TO_ZERO && in_exp != EXP_ONES)
         |-> (out_word[WORD_W-2:0] == {in_exp, in_sig[FRAC_W-1:0]}));
   end

endmodule

// File: tb/rnd_unit_bench.sv
module rnd_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_sign = 1'b0;
   logic [7:0]  in_exp = '0;
   logic [23:0] in_sig = '0;
   logic        in_guard = 1'b0;
   logic        in_round = 1'b0;
   logic        in_sticky = 1'b0;
   logic [1:0]  in_mode = '0;
   logic [31:0] out_word;
   logic        out_inexact;
   logic        out_overflow;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   rnd_unit u_rnd_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_sign      (in_sign),
      .in_exp       (in_exp),
      .in_sig       (in_sig),
      .in_guard     (in_guard),
      .in_round     (in_round),
      .in_sticky    (in_sticky),
      .in_mode      (in_mode),
      .out_word     (out_word),
      .out_inexact  (out_inexact),
      .out_overflow (out_overflow)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_case(input int mode, input int sgn, input int grs,
                           input int sig, input int ex);
      int rem;
      int up;
      int val;
      int e2;
      int carry;
      logic [31:0] exp_word;
      int ovf;
      string tag;
      @(negedge clk);
      in_mode   = mode[1:0];
      in_sign   = sgn[0];
      in_guard  = grs[2];
      in_round  = grs[1];
      in_sticky = grs[0];
      in_sig    = sig[23:0];
      in_exp    = ex[7:0];
      rem = grs;  // weight of the dropped bits in eighths of an ulp
      up = 0;
      case (mode)
         0: up = (rem > 4 || (rem == 4 && (sig % 2) == 1)) ? 1 : 0;
         1: up = 0;
         2: up = (rem != 0 && sgn == 0) ? 1 : 0;
         default: up = (rem != 0 && sgn == 1) ? 1 : 0;
      endcase
      val = sig + up;
      carry = 0;
      e2 = ex;
      if (val == 32'h0100_0000) begin
         val = 32'h0080_0000;
         e2 = ex + 1;
         carry = 1;
      end
      ovf = (e2 >= 255) ? 1 : 0;
      if (ovf != 0) exp_word = {sgn[0], 8'hFF, 23'h0};
      else          exp_word = {sgn[0], e2[7:0], val[22:0]};
      if (ovf != 0)          tag = "R8";
      else if (carry != 0)   tag = "R6";
      else if (rem == 0)     tag = "R10";
      else if (mode == 0)    tag = (rem == 4) ? "R2" : "R1";
      else if (mode == 1)    tag = "R3";
      else if (mode == 2)    tag = "R4";
      else                   tag = "R5";
      @(negedge clk);
      check(tag, out_word, exp_word);
      check("R7", {31'b0, out_inexact}, (rem != 0) ? 32'd1 : 32'd0);
      check("R8", {31'b0, out_overflow}, ovf[31:0]);
      check("R9", {31'b0, out_word[31]}, {31'b0, sgn[0]});
   endtask

   initial begin
      int sigs[6];
      int exps[4];
      sigs = '{32'h80_0000, 32'h80_0001, 32'hFF_FFFE, 32'hFF_FFFF, 32'hA5_A5A4, 32'hA5_A5A5};
      exps = '{1, 127, 253, 254};
      repeat (3) @(negedge clk);
      // R11: reset clears the word and both flags
      check("R11", out_word, 32'h0);
      check("R11", {30'b0, out_inexact, out_overflow}, 32'h0);
      rst_n = 1'b1;
      for (int m = 0; m < 4; m++)
         for (int sg = 0; sg < 2; sg++)
            for (int g = 0; g < 8; g++)
               for (int si = 0; si < 6; si++)
                  for (int ei = 0; ei < 4; ei++)
                     run_case(m, sg, g, sigs[si], exps[ei]);
      // R11: result registered one edge after the inputs, then held
      @(negedge clk);
      in_mode = 2'b01; in_sign = 1'b0; in_exp = 8'd100; in_sig = 24'hC0_0003;
      in_guard = 1'b0; in_round = 1'b0; in_sticky = 1'b0;
      @(posedge clk);
      #1;
      check("R11", out_word, {1'b0, 8'd100, 23'h40_0003});
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule